// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit up-counter with one compare register and one capture register. It can run in three modes. In event-count mode it counts edges on an external event input and wraps back to zero at a programmable compare value. In free-running capture mode it counts continuously and latches its value when a trigger arrives. In pulse-width mode it latches its value on every trigger edge and then restarts, so each captured value is the length of one trigger phase. Counts come either from a power-of-two prescaler on the system clock or from the synchronized event input.

Software sets up the block through a small word-wide register port and then starts it with a separate run input. Two single-cycle interrupt pulses report compare matches and captures. A toggle output changes state on every compare match. The first period after start is fully defined in every mode. A compare value of zero takes effect on the very first count. The first prescaled count takes a full period. A trigger that arrives before the first count is discarded.

Top module: `tmr16_top`

## Requirements
- R1: After reset the count, capture and control registers read 0, and `irq_match`, `irq_cap` and `tmr_out` are low.
- R2: Addresses are 0 for control, 1 for compare, 2 for capture (read-only) and 3 for the live count (read-only). `rd_data` follows `addr` combinationally. Control bits [3:0] hold the mode, bits [6:4] hold the prescaler select, and bit 7 selects the event input as the count source.
- R3: Mode 4'b0001 counts rising edges of `evt_in`, each seen after a two-flop synchronizer and counted exactly once. When the count equals the compare value at a count edge, the counter returns to 0, `irq_match` pulses for one cycle and `tmr_out` toggles. One period is therefore compare+1 events.
- R4: With a compare value of 0 in mode 4'b0001, every event, including the first after start, produces a match and leaves the count at 0.
- R5: In modes 4'b0101 and 4'b0110 with bit 7 clear, the count advances once every 2^select system clocks. The first increment comes exactly 2^select clocks after `run` rises. With bit 7 set, the count advances on synchronized `evt_in` rising edges instead.
- R6: In modes 4'b0101 and 4'b0110, a count edge at which the count equals the compare value pulses `irq_match` and toggles `tmr_out` without clearing the counter. The counter wraps from FFFFh to 0.
- R7: In mode 4'b0101, a synchronized rising edge of `cap_trig` copies the count into the capture register and pulses `irq_cap`. Falling edges are ignored.
- R8: In mode 4'b0110, both edges of `cap_trig` capture and pulse `irq_cap`, and the counter then restarts from 0.
- R9: A trigger edge after `run` rises but before the first count edge leaves the capture register unchanged and raises no `irq_cap`.
- R10: While `run` is low, the count reads 0, `tmr_out` is low and no interrupt is raised. After `run` rises again, counting restarts from 0.
- R11: Any other mode value keeps the count at 0 and raises no interrupt, even while `run` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register address for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| run | input | 1 | Timer enable |
| evt_in | input | 1 | Asynchronous external event input |
| cap_trig | input | 1 | Asynchronous capture trigger |
| irq_match | output | 1 | Compare-match interrupt pulse |
| irq_cap | output | 1 | Capture interrupt pulse |
| tmr_out | output | 1 | Toggle output |

## Verification
Event counting is tried with several pairs of compare value and event count. Some pairs end exactly on a period boundary and some end part-way through a period. Together they separate an off-by-one in the period length from an error in the remainder count. A compare value of zero is included, which shows whether the first count already matches. Prescaled runs are sampled one clock before and one clock after the expected first increment, which exposes a short first period. A full 16-bit wrap is also run. Capture is tried with a trigger before any count, then after counting, and with both edges in pulse-width mode. This separates a premature capture, an ignored falling edge and a missing restart after capture.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int MODE_W = 4;
  localparam int PSEL_W = 3;

  localparam logic [MODE_W-1:0] MODE_EVENT   = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_FREECAP = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_PULSEW  = 4'b0110;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CAP  = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  // control word: bit 7 event source, bits 6:4 prescaler select, bits 3:0 mode
  typedef struct packed {
    logic              ext_src;
    logic [PSEL_W-1:0] psel;
    logic [MODE_W-1:0] mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr16_sync_edge.sv
module tmr16_sync_edge #(
  parameter int STAGES = 2,
  parameter int N_EDGE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  output logic [N_EDGE-1:0] edges
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign edges[0] = sh_q[STAGES-1] & ~sh_q[STAGES];

  generate
    if (N_EDGE == 2) begin : g_fall
      assign edges[1] = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
  endgenerate

endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim  = DIV_W'((32'd1 << sel) - 32'd1);
    tick = run && (div_q == lim);
    if (!run || tick) div_d = '0;
    else              div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/tmr16_count_core.sv
module tmr16_count_core
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [MODE_W-1:0] mode,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic              tick,
  input  logic              trig_rise,
  input  logic              trig_fall,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cap,
  output logic              irq_match,
  output logic              irq_cap,
  output logic              tmr_out
);

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             started_q, started_d;
  logic             out_q, out_d;
  logic             im_q, im_d;
  logic             ic_q, ic_d;

  logic is_evt, is_fc, is_pw, active, hit, trig_ev;

  always_comb begin
    is_evt  = (mode == MODE_EVENT);
    is_fc   = (mode == MODE_FREECAP);
    is_pw   = (mode == MODE_PULSEW);
    active  = run && (is_evt || is_fc || is_pw);
    hit     = tick && (count_q == cmp_val);
    trig_ev = started_q && (((is_fc || is_pw) && trig_rise) || (is_pw && trig_fall));

    count_d   = count_q;
    cap_d     = cap_q;
    started_d = started_q;
    out_d     = out_q;
    im_d      = 1'b0;
    ic_d      = 1'b0;

    if (!active) begin
      count_d   = '0;
      started_d = 1'b0;
      out_d     = 1'b0;
    end else begin
      if (tick) begin
        started_d = 1'b1;
        if (hit) begin
          im_d    = 1'b1;
          out_d   = ~out_q;
          count_d = is_evt ? '0 : count_q + 1'b1;
        end else begin
          count_d = count_q + 1'b1;
        end
      end
      if (trig_ev) begin
        cap_d = count_q;
        ic_d  = 1'b1;
        if (is_pw) count_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      cap_q     <= '0;
      started_q <= 1'b0;
      out_q     <= 1'b0;
      im_q      <= 1'b0;
      ic_q      <= 1'b0;
    end else begin
      count_q   <= count_d;
      cap_q     <= cap_d;
      started_q <= started_d;
      out_q     <= out_d;
      im_q      <= im_d;
      ic_q      <= ic_d;
    end
  end

  assign count     = count_q;
  assign cap       = cap_q;
  assign irq_match = im_q;
  assign irq_cap   = ic_q;
  assign tmr_out   = out_q;

endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             run,
  input  logic             evt_in,
  input  logic             cap_trig,
  output logic             irq_match,
  output logic             irq_cap,
  output logic             tmr_out
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] count_w, cap_w;
  logic [MODE_W-1:0] mode_w;
  logic             evt_rise;
  logic [1:0]       trig_edges;
  logic             presc_tick;
  logic             tick;

  // register write path
  always_comb begin
    ctrl_d = ctrl_q;
    cmp_d  = cmp_q;
    if (wr_en && addr == ADDR_CTRL) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (wr_en && addr == ADDR_CMP)  cmp_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rd_data = CNT_W'(ctrl_q);
      ADDR_CMP:  rd_data = cmp_q;
      ADDR_CAP:  rd_data = cap_w;
      default:   rd_data = count_w;
    endcase
  end

  tmr16_sync_edge #(.STAGES(SYNC_STAGES), .N_EDGE(1)) u_evt_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (evt_in),
    .edges (evt_rise)
  );

  tmr16_sync_edge #(.STAGES(SYNC_STAGES), .N_EDGE(2)) u_trig_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cap_trig),
    .edges (trig_edges)
  );

  tmr16_prescaler #(.SEL_W(PSEL_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (ctrl_q.psel),
    .tick  (presc_tick)
  );

  assign mode_w = ctrl_q.mode;
  assign tick   = (ctrl_q.ext_src || mode_w == MODE_EVENT) ? evt_rise : presc_tick;

  tmr16_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mode      (mode_w),
    .cmp_val   (cmp_q),
    .tick      (tick),
    .trig_rise (trig_edges[0]),
    .trig_fall (trig_edges[1]),
    .count     (count_w),
    .cap       (cap_w),
    .irq_match (irq_match),
    .irq_cap   (irq_cap),
    .tmr_out   (tmr_out)
  );

endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [3:0]  mode,
  input logic [15:0] count,
  input logic        irq_match,
  input logic        irq_cap,
  input logic        tmr_out
);

  logic mode_ok;
  assign mode_ok = (mode == 4'b0001) || (mode == 4'b0101) || (mode == 4'b0110);

  // R10: idle timer stays silent and cleared
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!irq_match && !irq_cap));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == 16'd0 && !tmr_out));

  // R3: match interrupt is a single-cycle pulse
  p_match_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_match |=> !irq_match);

  // R3, R6: output changes only together with a match while running
  p_toggle_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run && mode_ok) && (tmr_out != $past(tmr_out))) |-> irq_match);

  // R11: unsupported modes never interrupt
  p_bad_mode_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |=> (!irq_match && !irq_cap));

endmodule

bind tmr16_top tmr16_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .mode      (mode_w),
  .count     (count_w),
  .irq_match (irq_match),
  .irq_cap   (irq_cap),
  .tmr_out   (tmr_out)
);

// File: tb/tmr16_top_bench.sv
`timescale 1ns/1ps
module tmr16_top_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        run;
  logic        evt_in;
  logic        cap_trig;
  logic        irq_match;
  logic        irq_cap;
  logic        tmr_out;

  int nchk = 0;
  int nerr = 0;
  int n_match = 0;
  int n_cap = 0;

  // event-count vectors: compare value, events, expected count, matches, output
  localparam int NV = 5;
  localparam logic [15:0] V_CMP [NV] = '{16'd0, 16'd3, 16'd2, 16'd7, 16'd1};
  localparam int          V_N   [NV] = '{5, 10, 3, 5, 6};
  localparam int          V_CNT [NV] = '{0, 2, 0, 5, 0};
  localparam int          V_MAT [NV] = '{5, 2, 1, 0, 3};
  localparam int          V_OUT [NV] = '{1, 0, 1, 0, 1};

  tmr16_top u_tmr16_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .run       (run),
    .evt_in    (evt_in),
    .cap_trig  (cap_trig),
    .irq_match (irq_match),
    .irq_cap   (irq_cap),
    .tmr_out   (tmr_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (irq_match) n_match++;
    if (irq_cap)   n_cap++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rd_data);
  endtask

  task automatic evt_pulse();
    @(negedge clk) evt_in = 1'b1;
    repeat (3) @(negedge clk);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic trig_set(input logic v);
    @(negedge clk) cap_trig = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic stop_run();
    @(negedge clk) run = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int v;
    int bm;
    int bc;
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = '0;
    run = 1'b0; evt_in = 1'b0; cap_trig = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rd(2'd3, v); chk("R1 count", v, 0);
    rd(2'd2, v); chk("R1 capture", v, 0);
    rd(2'd0, v); chk("R1 control", v, 0);
    chk("R1 outputs", int'({irq_match, irq_cap, tmr_out}), 0);

    // R2: control readback
    wr(2'd0, 16'h00A1);
    rd(2'd0, v); chk("R2 control readback", v, 16'h00A1);

    // R3/R4: vector table in event-count mode
    for (int i = 0; i < NV; i++) begin
      stop_run();
      wr(2'd0, 16'h0001);
      wr(2'd1, V_CMP[i]);
      @(negedge clk) run = 1'b1;
      bm = n_match;
      for (int j = 0; j < V_N[i]; j++) evt_pulse();
      rd(2'd3, v);
      chk(i == 0 ? "R4 count" : "R3 count", v, V_CNT[i]);
      chk(i == 0 ? "R4 matches" : "R3 matches", n_match - bm, V_MAT[i]);
      chk(i == 0 ? "R4 output" : "R3 output", int'(tmr_out), V_OUT[i]);
    end

    // R10: stop clears and suppresses
    stop_run();
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd5);
    @(negedge clk) run = 1'b1;
    repeat (3) evt_pulse();
    rd(2'd3, v); chk("R10 count before stop", v, 3);
    @(negedge clk) run = 1'b0;
    bm = n_match;
    rd(2'd3, v); chk("R10 count held", v, 0);
    repeat (2) evt_pulse();
    rd(2'd3, v); chk("R10 no count while stopped", v, 0);
    chk("R10 no match while stopped", n_match - bm, 0);
    @(negedge clk) run = 1'b1;
    evt_pulse();
    rd(2'd3, v); chk("R10 restart from zero", v, 1);

    // R5: prescaled first period, select 2
    stop_run();
    wr(2'd0, 16'h0025);
    wr(2'd1, 16'hFFFF);
    @(negedge clk) begin run = 1'b1; addr = 2'd3; end
    repeat (3) @(negedge clk);
    #1 chk("R5 no count before full period", int'(rd_data), 0);
    @(negedge clk);
    #1 chk("R5 first count at period", int'(rd_data), 1);
    repeat (36) @(negedge clk);
    #1 chk("R5 ten periods", int'(rd_data), 10);

    // R5: select 0 counts every clock
    stop_run();
    wr(2'd0, 16'h0005);
    @(negedge clk) begin run = 1'b1; addr = 2'd3; end
    @(negedge clk);
    #1 chk("R5 select 0 first clock", int'(rd_data), 1);

    // R6: free-running wrap with compare at FFFFh
    stop_run();
    bm = n_match;
    @(negedge clk) begin run = 1'b1; addr = 2'd3; end
    repeat (65536) @(negedge clk);
    #1 chk("R6 wrap to zero", int'(rd_data), 0);
    @(negedge clk);
    chk("R6 wrap match", n_match - bm, 1);
    chk("R6 output toggled", int'(tmr_out), 1);

    // R6: match without clear, event source
    stop_run();
    wr(2'd0, 16'h0085);
    wr(2'd1, 16'd2);
    @(negedge clk) run = 1'b1;
    bm = n_match;
    repeat (5) evt_pulse();
    rd(2'd3, v); chk("R6 no clear on match", v, 5);
    chk("R6 single match", n_match - bm, 1);

    // R9 then R7: capture before and after first count
    stop_run();
    wr(2'd1, 16'hFFFF);
    @(negedge clk) run = 1'b1;
    bc = n_cap;
    trig_set(1'b1);
    rd(2'd2, v); chk("R9 capture untouched", v, 0);
    chk("R9 no capture irq", n_cap - bc, 0);
    trig_set(1'b0);
    repeat (4) evt_pulse();
    trig_set(1'b1);
    rd(2'd2, v); chk("R7 captured count", v, 4);
    chk("R7 capture irq", n_cap - bc, 1);
    trig_set(1'b0);
    chk("R7 falling edge ignored", n_cap - bc, 1);

    // R8: pulse-width mode
    stop_run();
    wr(2'd0, 16'h0086);
    @(negedge clk) run = 1'b1;
    bc = n_cap;
    repeat (2) evt_pulse();
    trig_set(1'b1);
    rd(2'd2, v); chk("R8 rise capture", v, 2);
    rd(2'd3, v); chk("R8 restart after capture", v, 0);
    repeat (3) evt_pulse();
    trig_set(1'b0);
    rd(2'd2, v); chk("R8 fall capture", v, 3);
    chk("R8 capture irqs", n_cap - bc, 2);

    // R11: unsupported mode
    stop_run();
    wr(2'd0, 16'h0083);
    wr(2'd1, 16'd0);
    @(negedge clk) run = 1'b1;
    bm = n_match; bc = n_cap;
    repeat (3) evt_pulse();
    trig_set(1'b1);
    trig_set(1'b0);
    rd(2'd3, v); chk("R11 count stays zero", v, 0);
    chk("R11 no match irq", n_match - bm, 0);
    chk("R11 no capture irq", n_cap - bc, 0);

    stop_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule